// File: doc/BRIEF.md
# Nonmaskable Interrupt Request Latch

This block takes an asynchronous, unmaskable interrupt pin into the core clock domain and turns each low-to-high transition into a single pending request. The request waits until the core signals an instruction boundary. In that cycle the block asks the core to take the interrupt, names the vector to fetch and orders the interrupt-enable flag cleared.

The pin passes through a synchroniser with a configurable number of flops. The synchroniser has a fill tracker, so a pin that is already high when reset is released is treated as a level and not as an edge. A single pending flag holds the request. Nothing can mask it and nothing records that it is in service. An edge that arrives while the handler runs is therefore taken again at the next boundary, so the interrupt can nest on itself. An edge that lands in the same cycle as an acceptance is kept.

Top module: `nmi_req_latch`

## Requirements
- R1: A low-to-high transition on `nmi_pin` leads to exactly one `take_nmi` pulse, provided the pin is high at one rising clock edge and low at the edge before it.
- R2: While `nmi_pin` stays high at a steady level, no further requests are raised. Another request needs the pin to go low and then high again.
- R3: With default parameters (two synchroniser flops), suppose the pin is first sampled high at rising edge k and `insn_boundary` is held high. Then `take_nmi` is high in the cycle after edge k+2, and not before.
- R4: A pending request stays pending for any number of cycles while `insn_boundary` is low, and `take_nmi` stays low in that time. `take_nmi` is high only while `insn_boundary` is high. After `take_nmi` the request is cleared, unless R7 applies.
- R5: While `take_nmi` is high, `clr_ie` is high and `vec_num` equals `NMI_VECTOR` (default 2). In every other cycle both are 0.
- R6: No input masks or blocks a request. An edge that arrives after a take, while its own handler runs, is taken again at a later boundary.
- R7: An edge that is detected in the same cycle as a take leaves the request pending, so a second take follows at the next boundary.
- R8: A pin pulse that is high for exactly one clock period, spanning one rising edge, is registered as a request.
- R9: Reset clears the pending request. A pin held high through reset and after it raises no request until it has gone low and high again.
- R10: Several edges that arrive while a request is already pending merge into a single take.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_pin | input | 1 | Raw asynchronous interrupt pin |
| insn_boundary | input | 1 | High in a cycle where the core can accept an interrupt |
| take_nmi | output | 1 | Take-interrupt pulse |
| vec_num | output | VEC_W (8) | Vector number to fetch while taking, else 0 |
| clr_ie | output | 1 | Command to clear the interrupt-enable flag |

## Verification
The assertions check on every cycle that the pieces work together. A detected edge is always followed by a pending request. A request survives every cycle without a boundary. A take with no coincident edge empties the flag. A take with a coincident edge keeps it. Output commands only appear together with a take. The end-to-end behaviour is shown only by the bench's scenarios and its model sweep over pin and boundary patterns. That covers the exact three-edge latency from the pin, the effect of a pin held high across reset, one-period pulses, merging of repeated edges and re-entry during a handler.

// File: rtl/nmi_pkg.sv
package nmi_pkg;

  // Rising edge on a qualified sample stream: the previous sample must be
  // a genuine post-reset value for a low-to-high change to count.
  function automatic logic f_rise(input logic cur, input logic prev,
                                  input logic prev_ok);
    return prev_ok & cur & ~prev;
  endfunction

  // Next value of the pending flag: an accepted request drops out, a
  // fresh edge always wins so it cannot be lost.
  function automatic logic f_next_pend(input logic pend, input logic edge_hit,
                                       input logic accept);
    return edge_hit | (pend & ~accept);
  endfunction

  // Vector presented to the core while a take is in progress.
  function automatic logic [7:0] f_vec(input logic take, input logic [7:0] vec);
    return take ? vec : 8'd0;
  endfunction

endpackage

// File: rtl/nmi_sync.sv
module nmi_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic valid_o
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain_q;
  logic [LAST:0] fill_q;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            chain_q[0] <= 1'b0;
            fill_q[0]  <= 1'b0;
          end else begin
            chain_q[0] <= async_i;
            fill_q[0]  <= 1'b1;
          end
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            chain_q[g] <= 1'b0;
            fill_q[g]  <= 1'b0;
          end else begin
            chain_q[g] <= chain_q[g-1];
            fill_q[g]  <= fill_q[g-1];
          end
        end
      end
    end
  endgenerate

  assign level_o = chain_q[LAST];
  assign valid_o = fill_q[LAST];

  // R9: once the chain has filled it stays filled until the next reset
  assert_fill_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> valid_o);
endmodule

// File: rtl/nmi_edge_det.sv
module nmi_edge_det
  import nmi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  input  logic valid_i,
  output logic edge_o
);
  logic prev_q;
  logic prev_ok_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q    <= 1'b0;
      prev_ok_q <= 1'b0;
    end else begin
      prev_q    <= level_i;
      prev_ok_q <= valid_i;
    end
  end

  assign edge_o = f_rise(level_i, prev_q, prev_ok_q);

  // R2: an edge can only be reported when the synchronised level was low
  // one cycle earlier, so a steady high never retriggers
  assert_edge_needs_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> (level_i && !$past(level_i)));

  // R9: no edge before the synchroniser has produced two real samples
  assert_no_edge_unfilled_R9: assert property (@(posedge clk) disable iff (!rst_n)
    edge_o |-> $past(valid_i));
endmodule

// File: rtl/nmi_pend.sv
module nmi_pend
  import nmi_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic edge_i,
  input  logic boundary_i,
  output logic pend_o,
  output logic take_o
);
  logic pend_q;

  assign take_o = pend_q & boundary_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= f_next_pend(pend_q, edge_i, take_o);
  end

  assign pend_o = pend_q;

  // R1: every detected edge results in a pending request
  assert_edge_sets_pend_R1: assert property (@(posedge clk) disable iff (!rst_n)
    edge_i |=> pend_o);

  // R4: a request waits for a boundary
  assert_pend_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_o && !boundary_i) |=> pend_o);

  // R4: an acceptance with no new edge empties the flag
  assert_take_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !edge_i) |=> !pend_o);

  // R7: an edge coincident with acceptance is kept
  assert_coincident_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && edge_i) |=> pend_o);

  // R9: nothing becomes pending without an edge
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend_o && !edge_i) |=> !pend_o);
endmodule

// File: rtl/nmi_req_latch.sv
module nmi_req_latch
  import nmi_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          VEC_W       = 8,
  parameter logic [7:0]  NMI_VECTOR  = 8'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             nmi_pin,
  input  logic             insn_boundary,
  output logic             take_nmi,
  output logic [VEC_W-1:0] vec_num,
  output logic             clr_ie
);
  localparam int VW = (VEC_W < 8) ? VEC_W : 8;

  logic sync_level_w;
  logic sync_valid_w;
  logic edge_w;
  logic pend_w;
  logic take_w;
  logic [7:0] vec_full_w;

  nmi_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (nmi_pin),
    .level_o (sync_level_w),
    .valid_o (sync_valid_w)
  );

  nmi_edge_det edge_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .level_i (sync_level_w),
    .valid_i (sync_valid_w),
    .edge_o  (edge_w)
  );

  nmi_pend pend_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .edge_i     (edge_w),
    .boundary_i (insn_boundary),
    .pend_o     (pend_w),
    .take_o     (take_w)
  );

  assign vec_full_w = f_vec(take_w, NMI_VECTOR);
  assign take_nmi   = take_w;
  assign clr_ie     = take_w;

  always_comb begin
    vec_num = '0;
    vec_num[VW-1:0] = vec_full_w[VW-1:0];
  end

  // R4: a take is only issued at an instruction boundary from a held request
  assert_take_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |-> (insn_boundary && pend_w));

  // R4: back-to-back takes need a fresh edge in between
  assert_take_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> (!take_nmi || $past(edge_w)));

  // R5: the vector is idle whenever no take is in progress
  assert_vec_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !take_nmi |-> (vec_num == '0 && !clr_ie));
endmodule

// File: tb/nmi_req_latch_tb.sv
module nmi_req_latch_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] VEC = 8'd2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nmi_pin = 1'b0;
  logic insn_boundary = 1'b0;
  logic take_nmi;
  logic [7:0] vec_num;
  logic clr_ie;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // bench reference state: last three pin samples taken at rising edges,
  // number of edges since reset, and the expected pending flag
  logic h0, h1, h2;
  int   n_edges;
  logic m_pend;

  always #(CLK_PERIOD/2) clk = ~clk;

  nmi_req_latch dut_i (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin), .insn_boundary(insn_boundary),
    .take_nmi(take_nmi), .vec_num(vec_num), .clr_ie(clr_ie)
  );

  task automatic check1(input string tag, input string what,
                        input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // One clock cycle: drive at the falling edge, compare against the model,
  // then advance the model across the coming rising edge.
  task automatic step(input logic pin, input logic bnd, input string tag,
                      output logic seen);
    logic exp_take;
    logic rise;
    @(negedge clk);
    nmi_pin = pin;
    insn_boundary = bnd;
    #1;
    exp_take = m_pend && bnd;
    check1(tag, "take_nmi", {7'd0, take_nmi}, {7'd0, exp_take});
    check1(tag, "clr_ie (R5)", {7'd0, clr_ie}, {7'd0, exp_take});
    check1(tag, "vec_num (R5)", vec_num, exp_take ? VEC : 8'd0);
    seen = take_nmi;
    // edge visible this cycle: sample n-1 high, sample n-2 low, both real
    rise = (n_edges >= 3) && h1 && !h2;
    m_pend = rise || (m_pend && !exp_take);
    h2 = h1; h1 = h0; h0 = pin; n_edges++;
  endtask

  task automatic do_reset(input logic pin_during);
    @(negedge clk);
    rst_n = 1'b0;
    nmi_pin = pin_during;
    insn_boundary = 1'b0;
    h0 = 0; h1 = 0; h2 = 0; n_edges = 0; m_pend = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic run(input logic pin, input logic bnd, input int cycles,
                     input string tag);
    logic s;
    for (int i = 0; i < cycles; i++) step(pin, bnd, tag, s);
  endtask

  // count takes over a window
  task automatic count_takes(input logic pin, input logic bnd, input int cycles,
                             input string tag, output int cnt);
    logic s;
    cnt = 0;
    for (int i = 0; i < cycles; i++) begin
      step(pin, bnd, tag, s);
      if (s) cnt++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic s;
    int cnt;
    int lfsr;

    // reset state
    do_reset(1'b0);
    #1;
    check1("R9", "take after reset", {7'd0, take_nmi}, 8'd0);
    check1("R5", "vec after reset", vec_num, 8'd0);
    run(1'b0, 1'b1, 6, "R9");

    // R3: exact latency with boundary held high
    step(1'b1, 1'b1, "R3", s);
    check1("R3", "take at +0", {7'd0, s}, 8'd0);
    step(1'b1, 1'b1, "R3", s);
    check1("R3", "take at +1", {7'd0, s}, 8'd0);
    step(1'b1, 1'b1, "R3", s);
    check1("R3", "take at +2", {7'd0, s}, 8'd0);
    step(1'b1, 1'b1, "R3", s);
    check1("R3", "take at +3", {7'd0, s}, 8'd1);
    check1("R5", "vec during take", vec_num, VEC);
    // R2: steady high gives nothing more
    count_takes(1'b1, 1'b1, 20, "R2", cnt);
    check1("R2", "takes while steady high", cnt[7:0], 8'd0);

    // R1: low then high again gives exactly one take
    run(1'b0, 1'b1, 3, "R1");
    count_takes(1'b1, 1'b1, 10, "R1", cnt);
    check1("R1", "takes per edge", cnt[7:0], 8'd1);

    // R8: one-period pulse
    run(1'b0, 1'b1, 4, "R8");
    step(1'b1, 1'b1, "R8", s);
    count_takes(1'b0, 1'b1, 8, "R8", cnt);
    check1("R8", "one-period pulse takes", cnt[7:0], 8'd1);

    // R4: held with no boundary, then taken once
    step(1'b1, 1'b0, "R4", s);
    count_takes(1'b0, 1'b0, 30, "R4", cnt);
    check1("R4", "takes without boundary", cnt[7:0], 8'd0);
    count_takes(1'b0, 1'b1, 5, "R4", cnt);
    check1("R4", "takes once boundary comes", cnt[7:0], 8'd1);

    // R10: several edges while pending merge
    for (int k = 0; k < 4; k++) begin
      step(1'b1, 1'b0, "R10", s);
      step(1'b0, 1'b0, "R10", s);
    end
    run(1'b0, 1'b0, 4, "R10");
    count_takes(1'b0, 1'b1, 6, "R10", cnt);
    check1("R10", "merged takes", cnt[7:0], 8'd1);

    // R7: edge detected in the same cycle as a take.
    // First request pending with boundary low; second pin rise timed so its
    // edge is detected in the cycle where the boundary accepts the first.
    step(1'b1, 1'b0, "R7", s);
    run(1'b0, 1'b0, 4, "R7");
    step(1'b1, 1'b0, "R7", s);   // sampled at next edge k
    step(1'b1, 1'b0, "R7", s);   // after k
    step(1'b1, 1'b1, "R7", s);   // after k+1: edge now, take now
    check1("R7", "first take", {7'd0, s}, 8'd1);
    step(1'b1, 1'b0, "R7", s);
    check1("R7", "no take without boundary", {7'd0, s}, 8'd0);
    step(1'b1, 1'b1, "R7", s);
    check1("R7", "second take kept", {7'd0, s}, 8'd1);
    run(1'b0, 1'b1, 4, "R7");

    // R6: re-entry during handler, interrupt-enable cleared has no effect
    step(1'b1, 1'b1, "R6", s);
    count_takes(1'b1, 1'b1, 4, "R6", cnt);
    check1("R6", "first entry", cnt[7:0], 8'd1);
    step(1'b0, 1'b0, "R6", s);
    step(1'b1, 1'b0, "R6", s);
    run(1'b1, 1'b0, 6, "R6");
    count_takes(1'b1, 1'b1, 3, "R6", cnt);
    check1("R6", "nested entry", cnt[7:0], 8'd1);

    // R9: pin high through reset
    do_reset(1'b1);
    count_takes(1'b1, 1'b1, 20, "R9", cnt);
    check1("R9", "takes with pin high from reset", cnt[7:0], 8'd0);
    run(1'b0, 1'b1, 3, "R9");
    count_takes(1'b1, 1'b1, 6, "R9", cnt);
    check1("R9", "take after low-high", cnt[7:0], 8'd1);

    // R9: pending request dropped by reset
    step(1'b0, 1'b0, "R9", s);
    step(1'b1, 1'b0, "R9", s);
    run(1'b1, 1'b0, 4, "R9");
    do_reset(1'b0);
    count_takes(1'b0, 1'b1, 8, "R9", cnt);
    check1("R9", "pending cleared by reset", cnt[7:0], 8'd0);

    // R1: model sweep over all 8-bit pin patterns with pseudo-random boundary
    lfsr = 32'h1d;
    for (int p = 0; p < 256; p++) begin
      for (int b = 0; b < 8; b++) begin
        lfsr = (lfsr * 1103515245 + 12345) & 32'h7fffffff;
        step(p[b], lfsr[9] | lfsr[4], "R1", s);
      end
    end
    run(1'b0, 1'b1, 6, "R1");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule